// File: doc/BRIEF.md
# Complementary PWM Timer with Selectable Count Source

This block is a 16-bit up-counter that produces a pulse-width-modulated signal on one pin and its logical inverse on a second pin. Each time the counter is allowed to advance, it steps from zero up to a programmable period value and then wraps back to zero. The true output is high while the count is below a programmable compare value.

The counter advances on a count enable that comes from one of two sources. The first is a power-of-two divider of the peripheral clock, set by a 4-bit code. The second is an external event pin. That pin is synchronised into the clock domain, and each rising edge on it gives one step. Software configures the block through a write-strobe port with a 2-bit address.

A two-state controller governs operation. It has the states `ST_HALT` and `ST_RUN`. The transition START runs from `ST_HALT` to `ST_RUN` and is taken on a control write with the run bit set. The transition STOP runs from `ST_RUN` to `ST_HALT` and is taken on a control write with the run bit clear. In any other case each state holds.

Top module: `pwm_timer_top`

## Requirements
- R1: The register map is as follows.
  - Address 0 is control: bit0 is run, bit1 is the source select (0 = divided clock, 1 = event pin), and bit2 is a one-shot counter clear.
  - Address 1 holds the divide code in bits [3:0].
  - Address 2 holds the period.
  - Address 3 holds the compare value.
  - Reset leaves the block in `ST_HALT`, with source 0, code 0, period 0, compare 0 and counter 0. It drives `pwm_out`=0 and `pwm_out_n`=1.
- R2: Divide code N, for N from 0 to 14, gives one counter step every 2^N clock cycles while running.
- R3: Divide code 15 produces no counter steps.
- R4: With the source select at 1, the input passes through a two-flop synchronizer. Each rising edge of `evt_in` that stays high for at least two clocks and low for at least two clocks advances the counter by exactly one step.
- R5: A step taken at a count below the period adds one to the count. A step taken at a count equal to or above the period returns the count to 0.
- R6: While running, `pwm_out` is high exactly when the count is less than the compare value. `pwm_out_n` is always the inverse of `pwm_out`.
- R7: A compare value of 0 keeps `pwm_out` low. A compare value greater than the period keeps `pwm_out` high.
- R8: In `ST_HALT` the counter holds its value, `pwm_out` is 0 and `pwm_out_n` is 1. After START, counting resumes from the held value.
- R9: Writing control with bit2 set clears the counter to 0 in either state.
- R10: While in `ST_RUN`, writes to the source select and to the divide code are ignored.
- R11: START resets the clock divider, so the first step comes 2^N cycles after the START write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| evt_in | input | 1 | External event input (asynchronous) |
| pwm_out | output | 1 | True PWM output |
| pwm_out_n | output | 1 | Inverted PWM output |

## Verification
The assertions assume that register writes arrive as single-cycle strobes aligned to the clock. They also assume that `evt_in` meets the two-cycle minimum high and low widths, so that no edge is lost in the synchronizer. The bench drives every input on the falling clock edge. It holds each event level for three clocks and changes the divide code or source only while halted, except in the scenario that deliberately writes them while running.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_DIV    = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;
    localparam logic [1:0] ADDR_CMP    = 2'd3;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_SRC_BIT = 1;
    localparam int CTRL_CLR_BIT = 2;
endpackage

// File: rtl/pwm_evt_sync.sv
module pwm_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], evt_in};
        end
    end

    assign evt_rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W  = 14,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;
    logic             code_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (active) begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        code_ok = (int'(code) <= PRE_W);
        mask    = (PRE_W'(1) << code) - PRE_W'(1);
        tick    = active && code_ok && ((div_q & mask) == mask);
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             below
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            if (cnt >= period) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign below = (cnt < cmp);
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4,
    parameter int PRE_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             evt_in,
    output logic             pwm_out,
    output logic             pwm_out_n
);
    run_state_t        state_q, state_d;
    logic              running;
    logic              src_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              ctrl_wr;
    logic              go_cmd;
    logic              start;
    logic              clr;
    logic              pre_tick;
    logic              evt_rise;
    logic              step;
    logic [CNT_W-1:0]  cnt;
    logic              below;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign go_cmd  = wr_data[CTRL_RUN_BIT];
    assign clr     = ctrl_wr && wr_data[CTRL_CLR_BIT];
    assign start   = ctrl_wr && go_cmd && (state_q == ST_HALT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && go_cmd)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !go_cmd) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= 1'b0;
            code_q   <= '0;
            period_q <= '0;
            cmp_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL:   if (state_q == ST_HALT) src_q <= wr_data[CTRL_SRC_BIT];
                ADDR_DIV:    if (state_q == ST_HALT) code_q <= wr_data[CODE_W-1:0];
                ADDR_PERIOD: period_q <= wr_data;
                ADDR_CMP:    cmp_q <= wr_data;
                default:     ;
            endcase
        end
    end

    always_comb begin
        running   = 1'b0;
        pwm_out   = 1'b0;
        pwm_out_n = 1'b1;
        unique case (state_q)
            ST_HALT: begin
                running   = 1'b0;
                pwm_out   = 1'b0;
                pwm_out_n = 1'b1;
            end
            ST_RUN: begin
                running   = 1'b1;
                pwm_out   = below;
                pwm_out_n = ~below;
            end
            default: ;
        endcase
    end

    pwm_prescaler #(.PRE_W(PRE_W), .CODE_W(CODE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .active(running), .code(code_q), .tick(pre_tick)
    );

    pwm_evt_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_rise(evt_rise)
    );

    assign step = running && (src_q ? evt_rise : pre_tick);

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
        .period(period_q), .cmp(cmp_q), .cnt(cnt), .below(below)
    );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              step,
    input logic              clr,
    input logic              wr_en,
    input logic              src_q,
    input logic [CODE_W-1:0] code_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  period_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic              pwm_out,
    input logic              pwm_out_n
);
    // R8
    halt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pwm_out && pwm_out_n));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clr) |=> $stable(cnt));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && (cnt >= period_q)) |=> (cnt == '0));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R10
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en) |=> ($stable(code_q) && $stable(src_q)));

    // R3
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !src_q && (code_q == '1)) |-> !step);

    // R7
    cmp_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q == '0) |-> !pwm_out);
endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .step(step), .clr(clr),
    .wr_en(wr_en), .src_q(src_q), .code_q(code_q), .cnt(cnt),
    .period_q(period_q), .cmp_q(cmp_q), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
);

// File: tb/pwm_timer_top_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        evt_in = 1'b0;
    logic        pwm_out;
    logic        pwm_out_n;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    pwm_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_in(evt_in), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts high samples over n cycles, also tracks complement mismatches
    task automatic measure(input int n, output int highs, output int mism);
        highs = 0; mism = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            if (pwm_out_n != !pwm_out) mism++;
            @(negedge clk);
        end
    endtask

    task automatic run_len(output int len);
        len = 0;
        while (pwm_out && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic setup(input int code, input int per, input int cmpv);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(per));
        wr(2'd3, 16'(cmpv));
        wr(2'd0, 16'h0004);
        wr(2'd0, 16'h0001);
    endtask

    task automatic t_reset();
        check("R1 reset pwm_out", int'(pwm_out), 0);
        check("R1 reset pwm_out_n", int'(pwm_out_n), 1);
    endtask

    task automatic t_divide();
        int h, m;
        setup(0, 9, 4);
        measure(10, h, m);
        check("R2 R5 R6 code0 highs", h, 4);
        check("R6 complement", m, 0);
        setup(2, 9, 4);
        measure(40, h, m);
        check("R2 code2 highs", h, 16);
    endtask

    task automatic t_first_step();
        int len;
        setup(3, 9, 1);
        run_len(len);
        check("R11 first step after 8 cycles", len, 8);
    endtask

    task automatic t_extremes();
        int h, m;
        setup(0, 9, 0);
        measure(20, h, m);
        check("R7 cmp zero", h, 0);
        setup(0, 9, 12);
        measure(20, h, m);
        check("R7 cmp above period", h, 20);
    endtask

    task automatic t_halt_clear();
        int h, m, len;
        setup(0, 9, 6);
        @(negedge clk);
        wr(2'd0, 16'h0000);
        measure(20, h, m);
        check("R8 halted pwm_out", h, 0);
        check("R8 halted pwm_out_n", m, 0);
        wr(2'd0, 16'h0001);
        run_len(len);
        check("R8 resume from held count", len, 4);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0004);
        wr(2'd0, 16'h0001);
        run_len(len);
        check("R9 clear to zero", len, 6);
    endtask

    task automatic t_locked();
        int h, m;
        setup(0, 9, 4);
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0003);
        measure(20, h, m);
        check("R10 config writes ignored while running", h, 8);
    endtask

    task automatic t_reserved();
        int h, m;
        setup(15, 9, 6);
        measure(100, h, m);
        check("R3 code15 holds count", h, 100);
    endtask

    task automatic pulse(input int k);
        for (int i = 0; i < k; i++) begin
            evt_in = 1'b1; repeat (3) @(negedge clk);
            evt_in = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_external();
        int h, m;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'd9);
        wr(2'd3, 16'd6);
        wr(2'd0, 16'h0006);
        wr(2'd0, 16'h0003);
        measure(30, h, m);
        check("R4 no events no steps", h, 30);
        pulse(5);
        repeat (4) @(negedge clk);
        check("R4 five events below compare", int'(pwm_out), 1);
        pulse(1);
        repeat (4) @(negedge clk);
        check("R4 six events reach compare", int'(pwm_out), 0);
        pulse(4);
        repeat (4) @(negedge clk);
        check("R4 R5 ten events wrap", int'(pwm_out), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide();
        t_first_step();
        t_extremes();
        t_halt_clear();
        t_locked();
        t_reserved();
        t_external();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule